// File: doc/BRIEF.md
# Integer Execute Unit with Carry Flag

This block is the arithmetic and logic stage of a small 32-bit RISC pipeline. Each cycle it takes a decoded 6-bit opcode, two register operands and the low 16 bits of the instruction word. From these it forms a 32-bit result by combinational logic. It also owns two pieces of architectural state: a one-bit carry flag, and a latch for an immediate prefix. The carry flag feeds carry-in variants and shifts. The prefix latch lets one instruction supply the upper half of the next instruction's immediate.

The opcode bits act as modifiers. One bit swaps the second register for an immediate. One bit suppresses the carry update. One bit replaces the constant carry-in with the stored flag. Subtraction is reversed: the first operand is taken from the second. Compare reuses the subtract path and then overwrites the result MSB with the ordering of the two operands. State changes only on cycles where `issue_i` is high. A low `issue_i` is a stall, and the carry flag and the prefix latch hold their values through it.

Top module: `int_exec_carry`

## Requirements
- R1: For opcodes 00xxx0, the result is A + Bs + cin. Bs is the immediate when opcode bit 3 is set and operand B otherwise. cin is the carry flag when opcode bit 1 is set and 0 otherwise.
- R2: For opcodes 00xxx1, the result is Bs + NOT(A) + cin, with cin equal to the carry flag when opcode bit 1 is set and 1 otherwise. The exception is the compare case in R4/R5.
- R3: For an issued instruction in groups 00xxxx, the carry flag takes the carry-out of bit 31 on the next clock edge when opcode bit 2 is clear. When opcode bit 2 is set, the flag is unchanged.
- R4: Opcode 000101 with field bits [1:0] = 01 is a signed compare. The result is B + NOT(A) + 1, with bit 31 replaced by 1 when A > B signed and by 0 otherwise. The carry flag is unchanged.
- R5: Opcode 000101 with field bits [1:0] = 11 is the same compare, but the ordering used for bit 31 is unsigned.
- R6: Opcodes 10x0xx are bitwise operations on A and Bs, chosen by opcode bits [1:0]: 00 = OR, 01 = AND, 10 = XOR, 11 = Bs AND NOT(A). The carry flag is unchanged.
- R7: Opcode 100100 with field[6:0] = 0x01, 0x21 or 0x41 shifts A right by one bit. The new MSB is A[31] for 0x01, the old carry flag for 0x21, and 0 for 0x41. In all three cases the carry flag takes A[0].
- R8: Opcode 100100 with field[6:0] = 0x60 gives A[7:0] sign-extended to 32 bits. With field[6:0] = 0x61 it gives A[15:0] sign-extended. The carry flag is unchanged.
- R9: When the prefix latch is empty, the immediate is the 16-bit field sign-extended to 32 bits.
- R10: An issued opcode 101100 loads its 16-bit field into the prefix latch and gives result 0. The next issued instruction uses {latched bits, its own field} as its immediate. Any issued instruction other than 101100 empties the latch.
- R11: While issue_i is low, the carry flag and the prefix latch keep their values.
- R12: After reset, the carry flag is 0 and the prefix latch is empty.
- R13: Opcodes outside the groups above, and function codes under 100100 other than those in R7/R8, give result 0 and leave the carry flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | Instruction valid this cycle; low means stall |
| opcode_i | input | 6 | Decoded primary opcode |
| opa_i | input | 32 | First register operand (A) |
| opb_i | input | 32 | Second register operand (B) |
| field_i | input | 16 | Low 16 instruction bits: immediate or function code |
| result_o | output | 32 | Combinational result for the current instruction |
| carry_o | output | 1 | Current carry flag |

## Verification
Two kinds of event can land on the same instruction. The first is a pending immediate prefix meeting an immediate-form instruction that also consumes or updates the carry flag. The second is a stall that arrives between a prefix and its consumer. The bench provokes both cases directly: a prefix followed by a carry-in immediate add, and a prefix followed by idle cycles and then its consumer. It also mixes prefixes into the random stream at random points. In every case the bench judges the combinational result in the issue cycle and the carry flag after the following edge, against a reference model that tracks its own flag and latch.

// File: rtl/iex_pkg.sv
package iex_pkg;

    localparam int DATA_W = 32;
    localparam int FLD_W  = 16;
    localparam int HI_W   = DATA_W - FLD_W;
    localparam int FUNC_W = 7;

    localparam logic [5:0] OPC_PREFIX = 6'b101100;
    localparam logic [5:0] OPC_EXT    = 6'b100100;
    localparam logic [5:0] OPC_CMP    = 6'b000101;

    localparam int BIT_IMM  = 3;
    localparam int BIT_KEEP = 2;
    localparam int BIT_CIN  = 1;
    localparam int BIT_SUB  = 0;

    typedef enum logic [2:0] {
        GRP_ADD,
        GRP_SUB,
        GRP_LOGIC,
        GRP_EXT,
        GRP_PREFIX,
        GRP_NONE
    } iex_grp_e;

    typedef struct packed {
        logic            carry;
        logic            pfx_vld;
        logic [HI_W-1:0] pfx_bits;
    } iex_state_t;

    function automatic iex_grp_e iex_decode(input logic [5:0] opc);
        iex_grp_e g;
        if (opc[5:4] == 2'b00)
            g = opc[BIT_SUB] ? GRP_SUB : GRP_ADD;
        else if (opc[5:4] == 2'b10 && !opc[2])
            g = GRP_LOGIC;
        else if (opc == OPC_EXT)
            g = GRP_EXT;
        else if (opc == OPC_PREFIX)
            g = GRP_PREFIX;
        else
            g = GRP_NONE;
        return g;
    endfunction

endpackage

// File: rtl/iex_operand.sv
module iex_operand #(
    parameter int DATA_W = 32,
    parameter int FLD_W  = 16,
    localparam int HI_W  = DATA_W - FLD_W
) (
    input  logic [FLD_W-1:0]  field_i,
    input  logic              pfx_vld_i,
    input  logic [HI_W-1:0]   pfx_bits_i,
    input  logic              use_imm_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic [DATA_W-1:0] opb_sel_o
);
    logic [DATA_W-1:0] imm_sext;
    logic [DATA_W-1:0] imm_wide;
    logic [DATA_W-1:0] imm_val;

    always_comb begin
        imm_sext  = {{HI_W{field_i[FLD_W-1]}}, field_i};
        imm_wide  = {pfx_bits_i, field_i};
        imm_val   = pfx_vld_i ? imm_wide : imm_sext;
        opb_sel_o = use_imm_i ? imm_val : opb_i;
    end
endmodule

// File: rtl/iex_arith.sv
module iex_arith #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic              sub_i,
    input  logic              use_flag_i,
    input  logic              flag_i,
    input  logic              cmp_en_i,
    input  logic              cmp_uns_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o
);
    logic [DATA_W:0]   wide;
    logic [DATA_W-1:0] a_term;
    logic              cin;
    logic              a_gt_b;

    always_comb begin
        a_term = sub_i ? ~opa_i : opa_i;
        cin    = use_flag_i ? flag_i : sub_i;
        wide   = {1'b0, opb_i} + {1'b0, a_term} + {{DATA_W{1'b0}}, cin};
        a_gt_b = cmp_uns_i ? (opa_i > opb_i) : ($signed(opa_i) > $signed(opb_i));
        cout_o = wide[DATA_W];
        if (cmp_en_i)
            sum_o = {a_gt_b, wide[DATA_W-2:0]};
        else
            sum_o = wide[DATA_W-1:0];
    end
endmodule

// File: rtl/iex_bitops.sv
module iex_bitops #(
    parameter int DATA_W = 32,
    parameter int FUNC_W = 7
) (
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [1:0]        lsel_i,
    input  logic [FUNC_W-1:0] func_i,
    input  logic              flag_i,
    output logic [DATA_W-1:0] logic_o,
    output logic [DATA_W-1:0] ext_o,
    output logic              ext_sets_flag_o,
    output logic              ext_flag_o
);
    localparam int B_W = 8;
    localparam int H_W = 16;

    always_comb begin
        unique case (lsel_i)
            2'd0:    logic_o = opa_i | opb_i;
            2'd1:    logic_o = opa_i & opb_i;
            2'd2:    logic_o = opa_i ^ opb_i;
            default: logic_o = opb_i & ~opa_i;
        endcase
    end

    always_comb begin
        ext_o           = '0;
        ext_sets_flag_o = 1'b0;
        ext_flag_o      = opa_i[0];
        case (func_i)
            7'h01: begin
                ext_o           = {opa_i[DATA_W-1], opa_i[DATA_W-1:1]};
                ext_sets_flag_o = 1'b1;
            end
            7'h21: begin
                ext_o           = {flag_i, opa_i[DATA_W-1:1]};
                ext_sets_flag_o = 1'b1;
            end
            7'h41: begin
                ext_o           = {1'b0, opa_i[DATA_W-1:1]};
                ext_sets_flag_o = 1'b1;
            end
            7'h60: ext_o = {{(DATA_W-B_W){opa_i[B_W-1]}}, opa_i[B_W-1:0]};
            7'h61: ext_o = {{(DATA_W-H_W){opa_i[H_W-1]}}, opa_i[H_W-1:0]};
            default: ext_o = '0;
        endcase
    end
endmodule

// File: rtl/int_exec_carry.sv
module int_exec_carry
    import iex_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [5:0]        opcode_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [FLD_W-1:0]  field_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o
);
    iex_state_t state_d, state_q;
    iex_grp_e   grp;

    logic [DATA_W-1:0] opb_sel;
    logic [DATA_W-1:0] arith_sum;
    logic              arith_cout;
    logic              cmp_en;
    logic [DATA_W-1:0] logic_res;
    logic [DATA_W-1:0] ext_res;
    logic              ext_sets_flag;
    logic              ext_flag;
    logic              pfx_vld_w;

    assign grp       = iex_decode(opcode_i);
    assign cmp_en    = (opcode_i == OPC_CMP) && field_i[0];
    assign pfx_vld_w = state_q.pfx_vld;

    iex_operand #(.DATA_W(DATA_W), .FLD_W(FLD_W)) u_operand (
        .field_i    (field_i),
        .pfx_vld_i  (state_q.pfx_vld),
        .pfx_bits_i (state_q.pfx_bits),
        .use_imm_i  (opcode_i[BIT_IMM]),
        .opb_i      (opb_i),
        .opb_sel_o  (opb_sel)
    );

    iex_arith #(.DATA_W(DATA_W)) u_arith (
        .opa_i      (opa_i),
        .opb_i      (opb_sel),
        .sub_i      (opcode_i[BIT_SUB]),
        .use_flag_i (opcode_i[BIT_CIN]),
        .flag_i     (state_q.carry),
        .cmp_en_i   (cmp_en),
        .cmp_uns_i  (field_i[1]),
        .sum_o      (arith_sum),
        .cout_o     (arith_cout)
    );

    iex_bitops #(.DATA_W(DATA_W), .FUNC_W(FUNC_W)) u_bitops (
        .opa_i           (opa_i),
        .opb_i           (opb_sel),
        .lsel_i          (opcode_i[1:0]),
        .func_i          (field_i[FUNC_W-1:0]),
        .flag_i          (state_q.carry),
        .logic_o         (logic_res),
        .ext_o           (ext_res),
        .ext_sets_flag_o (ext_sets_flag),
        .ext_flag_o      (ext_flag)
    );

    always_comb begin
        state_d  = state_q;
        result_o = '0;
        unique case (grp)
            GRP_ADD, GRP_SUB: begin
                result_o = arith_sum;
                if (!opcode_i[BIT_KEEP])
                    state_d.carry = arith_cout;
            end
            GRP_LOGIC: result_o = logic_res;
            GRP_EXT: begin
                result_o = ext_res;
                if (ext_sets_flag)
                    state_d.carry = ext_flag;
            end
            default: result_o = '0;
        endcase
        state_d.pfx_vld = (grp == GRP_PREFIX);
        if (grp == GRP_PREFIX)
            state_d.pfx_bits = field_i[HI_W-1:0];
        if (!issue_i)
            state_d = state_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign carry_o = state_q.carry;

endmodule

module int_exec_carry_chk
    import iex_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              issue,
    input logic [5:0]        opcode,
    input logic [DATA_W-1:0] opa,
    input logic [DATA_W-1:0] opb,
    input logic [FLD_W-1:0]  field,
    input logic [DATA_W-1:0] result,
    input logic              carry,
    input logic              pfx_vld
);
    AST_STALL_HOLDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> $stable(carry)); // R11
    AST_STALL_HOLDS_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> $stable(pfx_vld)); // R11
    AST_KEEP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && opcode[5:4] == 2'b00 && opcode[2]) |=> $stable(carry)); // R3
    AST_SHIFT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && opcode == OPC_EXT && field[6:0] == 7'h41) |=> (carry == $past(opa[0]))); // R7
    AST_PREFIX_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && opcode == OPC_PREFIX) |=> pfx_vld); // R10
    AST_PREFIX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && opcode != OPC_PREFIX) |=> !pfx_vld); // R10
    AST_CMP_UNS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_CMP && field[1:0] == 2'b11) |-> (result[DATA_W-1] == (opa > opb))); // R5
    AST_PREFIX_RESULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OPC_PREFIX) |-> (result == '0)); // R10
endmodule

bind int_exec_carry int_exec_carry_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (issue_i),
    .opcode  (opcode_i),
    .opa     (opa_i),
    .opb     (opb_i),
    .field   (field_i),
    .result  (result_o),
    .carry   (carry_o),
    .pfx_vld (pfx_vld_w)
);

// File: tb/int_exec_carry_test.sv
module int_exec_carry_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [5:0]  opcode_i = '0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [15:0] field_i = '0;
    logic [31:0] result_o;
    logic        carry_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic        m_carry = 1'b0;
    logic        m_pv    = 1'b0;
    logic [15:0] m_pb    = '0;

    always #10 clk = ~clk;

    int_exec_carry uut (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .opcode_i(opcode_i),
        .opa_i(opa_i), .opb_i(opb_i), .field_i(field_i),
        .result_o(result_o), .carry_o(carry_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] f, output logic [31:0] res, output logic cn);
        logic [31:0] imm, bs;
        logic [32:0] s;
        logic sub, cin;
        imm = m_pv ? {m_pb, f} : {{16{f[15]}}, f};
        bs  = op[3] ? imm : b;
        res = '0;
        cn  = m_carry;
        if (op[5:4] == 2'b00) begin
            sub = op[0];
            cin = op[1] ? m_carry : sub;
            s   = {1'b0, bs} + {1'b0, (sub ? ~a : a)} + {32'd0, cin};
            res = s[31:0];
            if (!op[2]) cn = s[32];
            if (op == 6'b000101 && f[0])
                res[31] = f[1] ? (a > b) : ($signed(a) > $signed(b));
        end else if (op[5:4] == 2'b10 && !op[2]) begin
            case (op[1:0])
                2'd0: res = a | bs;
                2'd1: res = a & bs;
                2'd2: res = a ^ bs;
                default: res = bs & ~a;
            endcase
        end else if (op == 6'b100100) begin
            case (f[6:0])
                7'h01: begin res = {a[31], a[31:1]}; cn = a[0]; end
                7'h21: begin res = {m_carry, a[31:1]}; cn = a[0]; end
                7'h41: begin res = {1'b0, a[31:1]}; cn = a[0]; end
                7'h60: res = {{24{a[7]}}, a[7:0]};
                7'h61: res = {{16{a[15]}}, a[15:0]};
                default: res = '0;
            endcase
        end
    endtask

    task automatic step(input logic iss, input logic [5:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [15:0] f, input string req);
        logic [31:0] er;
        logic ec;
        @(negedge clk);
        issue_i = iss; opcode_i = op; opa_i = a; opb_i = b; field_i = f;
        model(op, a, b, f, er, ec);
        #2;
        if (iss) check({req, " result"}, result_o, er);
        @(posedge clk);
        #1;
        if (iss) begin
            m_carry = ec;
            if (op == 6'b101100) m_pb = f;
            m_pv = (op == 6'b101100);
        end
        check({req, " carry"}, {31'd0, carry_o}, {31'd0, m_carry});
        issue_i = 1'b0;
    endtask

    initial begin
        #(20 * 190000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd4711);
        repeat (3) @(posedge clk);
        #1;
        check("R12 carry after reset", {31'd0, carry_o}, 32'd0);
        rst_n = 1'b1;
        // R12: no prefix after reset, so an immediate add sign-extends
        step(1, 6'b001100, 32'd10, 32'd0, 16'hFFFF, "R12");
        // R1 / R3: overflow sets the flag
        step(1, 6'b000000, 32'hFFFF_FFFF, 32'd1, 16'd0, "R1 R3");
        // R1: carry-in add consumes the flag
        step(1, 6'b000110, 32'd5, 32'd7, 16'd0, "R1");
        // R2: reverse subtract 5 - 3
        step(1, 6'b000001, 32'd3, 32'd5, 16'd0, "R2");
        // R3: keep variant leaves flag alone, borrow case
        step(1, 6'b000101, 32'd9, 32'd2, 16'd0, "R3");
        step(1, 6'b000001, 32'd9, 32'd2, 16'd0, "R3 R2");
        // R4: signed compare, 1 > -1
        step(1, 6'b000101, 32'd1, 32'hFFFF_FFFF, 16'h0001, "R4");
        step(1, 6'b000101, 32'h8000_0000, 32'd3, 16'h0001, "R4");
        // R5: unsigned compare
        step(1, 6'b000101, 32'd1, 32'hFFFF_FFFF, 16'h0003, "R5");
        step(1, 6'b000101, 32'h8000_0000, 32'd3, 16'h0003, "R5");
        // R6: all four logic operations, register and immediate form
        for (int k = 0; k < 4; k++) begin
            step(1, {4'b1000, k[1:0]}, 32'hF0F0_1234, 32'h0FF0_FF00, 16'd0, "R6");
            step(1, {4'b1010, k[1:0]}, 32'hF0F0_1234, 32'd0, 16'h8F0F, "R6");
        end
        // R7: shifts, through-carry after setting the flag
        step(1, 6'b100100, 32'h8000_0003, 32'd0, 16'h0001, "R7");
        step(1, 6'b100100, 32'h0000_0002, 32'd0, 16'h0021, "R7");
        step(1, 6'b100100, 32'h8000_0001, 32'd0, 16'h0041, "R7");
        step(1, 6'b100100, 32'h8000_0001, 32'd0, 16'h0021, "R7");
        // R8: sign extension
        step(1, 6'b100100, 32'h1234_5680, 32'd0, 16'h0060, "R8");
        step(1, 6'b100100, 32'h1234_8001, 32'd0, 16'h0061, "R8");
        step(1, 6'b100100, 32'h1234_7F01, 32'd0, 16'h0061, "R8");
        // R9: negative immediate sign-extended
        step(1, 6'b001000, 32'd100, 32'd0, 16'h8000, "R9");
        // R10: prefix widens next immediate, then clears
        step(1, 6'b101100, 32'd0, 32'd0, 16'h1234, "R10");
        step(1, 6'b001110, 32'd1, 32'd0, 16'h8000, "R10");
        step(1, 6'b001100, 32'd1, 32'd0, 16'h8000, "R10 R9");
        // R11: stall between prefix and consumer
        step(1, 6'b101100, 32'd0, 32'd0, 16'hABCD, "R11");
        step(0, 6'b000000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'd0, "R11");
        step(0, 6'b100100, 32'h1, 32'd0, 16'h0001, "R11");
        step(1, 6'b101000, 32'd0, 32'd0, 16'h0001, "R11 R10");
        // R13: unrecognised opcode and function code
        step(1, 6'b000000, 32'hFFFF_FFFF, 32'd1, 16'd0, "R13");
        step(1, 6'b110010, 32'h5, 32'h6, 16'h7, "R13");
        step(1, 6'b100100, 32'h5, 32'h6, 16'h0007, "R13");
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [5:0] op;
            logic [15:0] f;
            string tag;
            f = 16'($urandom);
            case ($urandom % 6)
                0: begin op = {2'b00, 4'($urandom)}; tag = "R1 R2 R3 random"; end
                1: begin op = 6'b000101; f[0] = 1'b1; tag = "R4 R5 random"; end
                2: begin op = {2'b10, 1'($urandom), 1'b0, 2'($urandom)}; tag = "R6 random"; end
                3: begin
                    op = 6'b100100;
                    case ($urandom % 5)
                        0: f[6:0] = 7'h01;
                        1: f[6:0] = 7'h21;
                        2: f[6:0] = 7'h41;
                        3: f[6:0] = 7'h60;
                        default: f[6:0] = 7'h61;
                    endcase
                    tag = "R7 R8 random";
                end
                4: begin op = 6'b101100; tag = "R10 random"; end
                default: begin op = {2'b00, 1'b1, 3'($urandom)}; tag = "R9 R10 random"; end
            endcase
            step(($urandom % 8) != 0, op, $urandom, $urandom, f, tag);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule